// File: doc/BRIEF.md
# Synchronised DAC-Update and Eight-Channel ADC Acquisition Sequencer

This block runs a repeating acquisition frame from a free-running frame pacer. A frame starts with a 16-bit setpoint being shifted out to a single DAC on its own serial port. Only after the DAC chip select has returned high does the block pull a shared active-low conversion strobe low, so that all eight converters sample at one instant. After a programmable settling wait it reads the eight 18-bit results at the same time, each over that converter's own serial clock, chip select and data line.

Once all eight results are in, the block writes them one per clock into an on-chip dual-port sample memory. Each entry holds the channel number, the frame number and the sample. The second memory port is a plain registered read port, so another agent can drain the samples without disturbing acquisition. A frame tick that arrives while a frame is still in progress is discarded and raises a sticky overrun flag.

Top module: `acq_sequencer`

## Requirements
- R1: Within a frame the DAC transfer finishes (DAC chip select high) before the conversion strobe goes low, and no ADC chip select is low while the DAC chip select is low.
- R2: The DAC receives the value of `dac_word` captured at the frame tick: exactly 16 bits, MSB first, on the DAC serial port in SPI mode 0 (clock idles low, data changes only while the clock is low, the receiver samples on the rising clock edge).
- R3: `adc_trig_n` goes low for exactly `trig_len` system clocks per frame, and a `trig_len` of 0 acts as 1.
- R4: All ADC chip selects fall together exactly `conv_wait`+2 system clocks after `adc_trig_n` returns high. Each channel then clocks in 18 bits MSB first, sampling its data line on the rising edge of its own serial clock.
- R5: The DAC serial clock period is 2*DAC_HALF system clocks and the ADC serial clock period is 2*ADC_HALF system clocks. With the defaults at 250 MHz these are 25 MHz and about 41.7 MHz, below the 30 MHz and 50 MHz limits.
- R6: After each readout, channels 0 to 7 are written in ascending order on consecutive clocks. Each entry is channel in bits [28:26], frame number in bits [25:18] and sample in bits [17:0]. The same entry appears on `buf_wdata` and is stored in the sample memory.
- R7: The write address advances by one per entry and wraps from DEPTH-1 to 0. It is not reset by `enable`.
- R8: While `enable` is high a frame tick occurs every `frame_period` system clocks; no ticks occur while it is low. A tick that arrives while `busy` is high is dropped and sets `overrun`. `overrun` stays set until `enable` is low.
- R9: After reset every chip select and the conversion strobe are high, all serial clocks are low, and `busy`, `overrun` and `buf_we` are 0.
- R10: The frame number restarts at 0 on each enable and increments by one per accepted frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the frame pacer; low clears overrun and frame number |
| dac_word | input | 16 | Setpoint captured at each accepted frame tick |
| frame_period | input | 16 | Frame tick spacing in system clocks |
| trig_len | input | 8 | Conversion strobe low time in system clocks |
| conv_wait | input | 8 | Extra wait between strobe release and readout |
| dac_sclk | output | 1 | DAC serial clock |
| dac_cs_n | output | 1 | DAC chip select, active low |
| dac_mosi | output | 1 | DAC serial data |
| adc_trig_n | output | 1 | Shared conversion strobe, active low |
| adc_sclk | output | 8 | Per-channel ADC serial clocks |
| adc_cs_n | output | 8 | Per-channel ADC chip selects, active low |
| adc_miso | input | 8 | Per-channel ADC serial data |
| buf_we | output | 1 | Sample memory write strobe |
| buf_waddr | output | 5 | Sample memory write address |
| buf_wdata | output | 29 | Sample memory entry being written |
| rd_addr | input | 5 | Read port address |
| rd_data | output | 29 | Read port data, one clock after address |
| busy | output | 1 | High while a frame is in progress |
| overrun | output | 1 | Sticky dropped-tick flag |

## Verification
A wrong sequencer state shows at the pins within the frame in which it happens. A misordered step shows as the strobe falling while the DAC select is still low. A miscounted timer shows as a strobe width or strobe-to-select gap that is off by a clock. A bad bit counter shows as a DAC word with the wrong bit count or a shifted ADC sample. Address or channel bookkeeping errors only become visible when the memory is read back after a wrap, so the bench runs enough frames to overwrite half the memory and then reads back every location.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DAC,
    ST_TRIG,
    ST_WAIT,
    ST_READ,
    ST_STORE
  } seq_state_t;
endpackage

// File: rtl/frame_pacer.sv
module frame_pacer #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [PW-1:0] period,
  output logic          tick
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] limit;

  assign limit = (period == '0) ? '0 : period - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= limit) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_GATED: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !tick); // R8
endmodule

// File: rtl/dac_shifter.sv
module dac_shifter #(
  parameter int W    = 16,
  parameter int HALF = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] word,
  output logic         sclk,
  output logic         cs_n,
  output logic         sdo,
  output logic         done
);
  localparam int HW = $clog2(HALF + 1);
  localparam int BW = $clog2(W + 1);

  logic          active;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bits;
  logic [W-1:0]  sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      sdo    <= 1'b0;
      done   <= 1'b0;
      hcnt   <= '0;
      bits   <= '0;
      sh     <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          cs_n   <= 1'b0;
          sclk   <= 1'b0;
          hcnt   <= '0;
          bits   <= '0;
          sh     <= word;
          sdo    <= word[W-1];
        end
      end else if (hcnt == HW'(HALF - 1)) begin
        hcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bits == BW'(W - 1)) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            sdo    <= 1'b0;
            done   <= 1'b1;
          end else begin
            bits <= bits + 1'b1;
            sdo  <= sh[W-2];
            sh   <= {sh[W-2:0], 1'b0};
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  AST_DAC_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk); // R2
  AST_DAC_SDO_HELD: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdo)); // R2
endmodule

// File: rtl/adc_reader.sv
module adc_reader #(
  parameter int W    = 18,
  parameter int HALF = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         sdi,
  output logic         sclk,
  output logic         cs_n,
  output logic [W-1:0] word,
  output logic         done
);
  localparam int HW = $clog2(HALF + 1);
  localparam int BW = $clog2(W + 1);

  logic          active;
  logic [HW-1:0] hcnt;
  logic [BW-1:0] bits;
  logic [W-1:0]  sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cs_n   <= 1'b1;
      sclk   <= 1'b0;
      done   <= 1'b0;
      hcnt   <= '0;
      bits   <= '0;
      sh     <= '0;
      word   <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (go) begin
          active <= 1'b1;
          cs_n   <= 1'b0;
          sclk   <= 1'b0;
          hcnt   <= '0;
          bits   <= '0;
        end
      end else if (hcnt == HW'(HALF - 1)) begin
        hcnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
          sh   <= {sh[W-2:0], sdi};
        end else begin
          sclk <= 1'b0;
          if (bits == BW'(W - 1)) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b1;
            word   <= sh;
          end else begin
            bits <= bits + 1'b1;
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  AST_ADC_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk); // R4
  AST_ADC_DONE_CS: assert property (@(posedge clk) disable iff (rst)
    done |-> cs_n); // R4
endmodule

// File: rtl/sample_ram.sv
module sample_ram #(
  parameter int DW    = 29,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int NCH      = 8,
  parameter int DAC_W    = 16,
  parameter int ADC_W    = 18,
  parameter int DAC_HALF = 5,
  parameter int ADC_HALF = 3,
  parameter int FRAME_W  = 8,
  parameter int DEPTH    = 32,
  parameter int PERIOD_W = 16,
  parameter int TIME_W   = 8,
  localparam int CH_W    = $clog2(NCH),
  localparam int AW      = $clog2(DEPTH),
  localparam int ENT_W   = CH_W + FRAME_W + ADC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [DAC_W-1:0]    dac_word,
  input  logic [PERIOD_W-1:0] frame_period,
  input  logic [TIME_W-1:0]   trig_len,
  input  logic [TIME_W-1:0]   conv_wait,
  output logic                dac_sclk,
  output logic                dac_cs_n,
  output logic                dac_mosi,
  output logic                adc_trig_n,
  output logic [NCH-1:0]      adc_sclk,
  output logic [NCH-1:0]      adc_cs_n,
  input  logic [NCH-1:0]      adc_miso,
  output logic                buf_we,
  output logic [AW-1:0]       buf_waddr,
  output logic [ENT_W-1:0]    buf_wdata,
  input  logic [AW-1:0]       rd_addr,
  output logic [ENT_W-1:0]    rd_data,
  output logic                busy,
  output logic                overrun
);
  seq_state_t         state;
  logic               tick;
  logic               dac_go, dac_done, adc_go;
  logic [DAC_W-1:0]   dac_latch;
  logic [TIME_W-1:0]  tcnt, wcnt;
  logic [FRAME_W-1:0] frame_cnt, cur_frame;
  logic [CH_W-1:0]    ch;
  logic [AW-1:0]      wptr;
  logic [NCH-1:0]     adc_done;
  logic [ADC_W-1:0]   adc_word [NCH];

  frame_pacer #(.PW(PERIOD_W)) u_pacer (
    .clk(clk), .rst(rst), .enable(enable), .period(frame_period), .tick(tick)
  );

  dac_shifter #(.W(DAC_W), .HALF(DAC_HALF)) u_dac (
    .clk(clk), .rst(rst), .go(dac_go), .word(dac_latch),
    .sclk(dac_sclk), .cs_n(dac_cs_n), .sdo(dac_mosi), .done(dac_done)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_adc
    adc_reader #(.W(ADC_W), .HALF(ADC_HALF)) u_rd (
      .clk(clk), .rst(rst), .go(adc_go), .sdi(adc_miso[g]),
      .sclk(adc_sclk[g]), .cs_n(adc_cs_n[g]), .word(adc_word[g]),
      .done(adc_done[g])
    );
  end

  sample_ram #(.DW(ENT_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      dac_go     <= 1'b0;
      adc_go     <= 1'b0;
      dac_latch  <= '0;
      adc_trig_n <= 1'b1;
      tcnt       <= '0;
      wcnt       <= '0;
      frame_cnt  <= '0;
      cur_frame  <= '0;
      ch         <= '0;
      wptr       <= '0;
      buf_we     <= 1'b0;
      buf_waddr  <= '0;
      buf_wdata  <= '0;
      overrun    <= 1'b0;
    end else begin
      dac_go <= 1'b0;
      adc_go <= 1'b0;
      buf_we <= 1'b0;
      if (!enable) begin
        overrun   <= 1'b0;
        frame_cnt <= '0;
      end else if (tick && state != ST_IDLE) begin
        overrun <= 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (tick && enable) begin
            dac_latch <= dac_word;
            dac_go    <= 1'b1;
            cur_frame <= frame_cnt;
            frame_cnt <= frame_cnt + 1'b1;
            state     <= ST_DAC;
          end
        end
        ST_DAC: begin
          if (dac_done) begin
            adc_trig_n <= 1'b0;
            tcnt       <= (trig_len == '0) ? TIME_W'(1) : trig_len;
            state      <= ST_TRIG;
          end
        end
        ST_TRIG: begin
          if (tcnt <= TIME_W'(1)) begin
            adc_trig_n <= 1'b1;
            wcnt       <= conv_wait;
            state      <= ST_WAIT;
          end else begin
            tcnt <= tcnt - 1'b1;
          end
        end
        ST_WAIT: begin
          if (wcnt == '0) begin
            adc_go <= 1'b1;
            state  <= ST_READ;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
        end
        ST_READ: begin
          if (&adc_done) begin
            ch    <= '0;
            state <= ST_STORE;
          end
        end
        ST_STORE: begin
          buf_we    <= 1'b1;
          buf_waddr <= wptr;
          buf_wdata <= {ch, cur_frame, adc_word[ch]};
          wptr      <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
          if (ch == CH_W'(NCH - 1)) state <= ST_IDLE;
          else ch <= ch + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_TRIG_AFTER_DAC: assert property (@(posedge clk) disable iff (rst)
    !adc_trig_n |-> dac_cs_n); // R1
  AST_ADC_QUIET_IN_DAC: assert property (@(posedge clk) disable iff (rst)
    !dac_cs_n |-> (&adc_cs_n)); // R1
  AST_ADC_CS_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    ((&adc_cs_n) || !(|adc_cs_n))); // R4
  AST_TRIG_HIGH_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> adc_trig_n); // R3
  AST_WADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (buf_we && $past(buf_we)) |->
      buf_waddr == (($past(buf_waddr) == AW'(DEPTH - 1)) ? '0 : $past(buf_waddr) + 1'b1)); // R7
  AST_OVERRUN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !overrun); // R8
endmodule

// File: tb/acq_sequencer_test.sv
module acq_sequencer_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        enable;
  logic [15:0] dac_word;
  logic [15:0] frame_period;
  logic [7:0]  trig_len, conv_wait;
  logic        dac_sclk, dac_cs_n, dac_mosi, adc_trig_n;
  logic [7:0]  adc_sclk, adc_cs_n, adc_miso;
  logic        buf_we, busy, overrun;
  logic [4:0]  buf_waddr, rd_addr;
  logic [28:0] buf_wdata, rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  acq_sequencer uut (
    .clk(clk), .rst(rst), .enable(enable), .dac_word(dac_word),
    .frame_period(frame_period), .trig_len(trig_len), .conv_wait(conv_wait),
    .dac_sclk(dac_sclk), .dac_cs_n(dac_cs_n), .dac_mosi(dac_mosi),
    .adc_trig_n(adc_trig_n), .adc_sclk(adc_sclk), .adc_cs_n(adc_cs_n),
    .adc_miso(adc_miso), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .overrun(overrun)
  );

  function automatic logic [17:0] samp(int f, int c);
    return 18'((f * 4099 + c * 21803 + 1234) ^ (c << 14));
  endfunction

  function automatic logic [15:0] dword(int k);
    return 16'(16'hA5C3 ^ (k * 16'h1357));
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ADC models: value chosen at strobe fall, bits change on falling SCLK
  for (genvar g = 0; g < 8; g++) begin : g_model
    int n = 0;
    int idx = 0;
    logic [17:0] val = '0;
    always @(negedge adc_trig_n) begin
      val = samp(n, g);
      n++;
    end
    always @(negedge adc_sclk[g] or posedge adc_cs_n[g]) begin
      if (adc_cs_n[g]) idx = 0;
      else idx++;
    end
    assign adc_miso[g] = (idx < 18) ? val[17 - idx] : 1'b0;
  end

  // DAC model: samples on rising SCLK, records word at chip select release
  logic [15:0] dsh = '0;
  int dbits = 0;
  int dk = 0;
  logic [15:0] dac_seen [16];
  int dac_nb [16];
  always @(posedge dac_sclk or posedge dac_cs_n) begin
    if (dac_cs_n) begin
      if (dbits > 0 && dk < 16) begin
        dac_seen[dk] = dsh;
        dac_nb[dk] = dbits;
        dk++;
      end
      dbits = 0;
    end else begin
      dsh = {dsh[14:0], dac_mosi};
      dbits++;
    end
  end

  // Pin timing monitor, sampled on the falling system clock edge
  int tlow = 0, tn = 0, tf = 0, gcnt = 0, ovl = 0, cyc = 0;
  bit gap_run = 0, tprev = 1, dprev = 0, aprev = 0;
  int tw [16];
  int gp [16];
  int tw_last = 0, gp_last = 0;
  int dlast = 0, alast = 0;
  int dper_min = 1000000, aper_min = 1000000;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (!adc_trig_n && tprev) tf++;
      tprev = adc_trig_n;
      if (!adc_trig_n) tlow++;
      else if (tlow > 0) begin
        tw[tn % 16] = tlow;
        tw_last = tlow;
        tlow = 0;
        gap_run = 1;
        gcnt = 0;
      end
      if (gap_run) begin
        if (adc_cs_n[0]) gcnt++;
        else begin
          gp[tn % 16] = gcnt;
          gp_last = gcnt;
          tn++;
          gap_run = 0;
        end
      end
      if ((!adc_trig_n && !dac_cs_n) || (!dac_cs_n && adc_cs_n != 8'hFF)) ovl++;
      if (dac_sclk && !dprev) begin
        if (dlast > 0 && cyc - dlast < dper_min) dper_min = cyc - dlast;
        dlast = cyc;
      end
      if (adc_sclk[0] && !aprev) begin
        if (alast > 0 && cyc - alast < aper_min) aper_min = cyc - alast;
        alast = cyc;
      end
      dprev = dac_sclk;
      aprev = adc_sclk[0];
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    int tf0;
    rst = 1'b1;
    enable = 1'b0;
    dac_word = dword(0);
    frame_period = 16'd400;
    trig_len = 8'd4;
    conv_wait = 8'd3;
    rd_addr = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 dac_cs_n", 64'(dac_cs_n), 64'd1);
    chk("R9 adc_cs_n", 64'(adc_cs_n), 64'hFF);
    chk("R9 trig", 64'(adc_trig_n), 64'd1);
    chk("R9 sclks", 64'({dac_sclk, adc_sclk}), 64'd0);
    chk("R9 busy/overrun/we", 64'({busy, overrun, buf_we}), 64'd0);
    repeat (600) @(negedge clk);
    chk("R8 no frame while disabled", 64'({busy, tf}), 64'd0);

    enable = 1'b1;
    for (int k = 0; k < 6; k++) begin
      wait (tf == k + 1);
      @(negedge clk);
      dac_word = dword(k + 1);
    end
    enable = 1'b0;
    wait (!busy);
    repeat (20) @(negedge clk);

    for (int k = 0; k < 6; k++) begin
      chk($sformatf("R2 dac word frame %0d", k), 64'(dac_seen[k]), 64'(dword(k)));
      chk($sformatf("R2 dac bits frame %0d", k), 64'(dac_nb[k]), 64'd16);
      chk($sformatf("R3 trig width frame %0d", k), 64'(tw[k]), 64'd4);
      chk($sformatf("R4 gap frame %0d", k), 64'(gp[k]), 64'd5);
    end
    chk("R1 no overlap", 64'(ovl), 64'd0);
    chk("R5 dac sclk period", 64'(dper_min), 64'd10);
    chk("R5 adc sclk period", 64'(aper_min), 64'd6);
    chk("R8 no overrun at slow rate", 64'(overrun), 64'd0);

    for (int a = 0; a < 32; a++) begin
      int nw, f, c;
      @(negedge clk);
      rd_addr = 5'(a);
      @(negedge clk);
      nw = (a + 32 < 48) ? a + 32 : a;
      f = nw / 8;
      c = nw % 8;
      chk($sformatf("R6 R7 entry addr %0d", a), 64'(rd_data),
          64'({3'(c), 8'(f), samp(f, c)}));
    end

    // Fast frame rate: overrun, shortest strobe, zero wait, frame restart
    trig_len = 8'd0;
    conv_wait = 8'd0;
    frame_period = 16'd150;
    tf0 = tf;
    @(negedge clk);
    enable = 1'b1;
    while (!buf_we) @(negedge clk);
    chk("R7 address continues after wrap", 64'(buf_waddr), 64'd16);
    chk("R10 frame restarts at 0", 64'(buf_wdata[25:18]), 64'd0);
    chk("R6 first channel 0", 64'(buf_wdata[28:26]), 64'd0);
    @(negedge clk);
    chk("R6 second channel 1", 64'({buf_we, buf_wdata[28:26]}), 64'({1'b1, 3'd1}));
    repeat (900) @(negedge clk);
    chk("R8 overrun set", 64'(overrun), 64'd1);
    chk("R3 trig_len 0 acts as 1", 64'(tw_last), 64'd1);
    chk("R4 gap with zero wait", 64'(gp_last), 64'd2);
    chk("R8 ticks dropped", 64'((tf - tf0 >= 2) && (tf - tf0 <= 5)), 64'd1);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 overrun cleared by disable", 64'(overrun), 64'd0);
    wait (!busy);
    repeat (10) @(negedge clk);
    chk("R1 no overlap fast rate", 64'(ovl), 64'd0);
    finish_run();
  end
endmodule